// File: doc/BRIEF.md
# USB Bridge Register Decoder with FIFO Window Remap

This block is the register front end of a USB on-the-go bridge. A host bus presents a 12-bit byte offset with a byte, halfword or word access. Two upper address windows belong to an inner USB core: a register window whose offsets pass straight through, and a FIFO window in which every 32-byte slice is folded into one endpoint FIFO address of the core. Everything else is decoded locally as 32-bit system registers, and only whole-word accesses reach them.

The local registers are a device configuration word that selects host mode, an endpoint-0 transfer configuration, fifteen transmit-size and fifteen receive-size registers for endpoints 1 to 15, a scratch word, a production-test reset word, and read-only revision and identification constants. Any write to an endpoint configuration register also sends a one-cycle size command to the core, carrying the endpoint number, the transfer size and the direction. A write that tries to set the production test mode bit does not enter that mode: the bit is dropped and a sticky error flag is raised.

Forwarded accesses drive the core strobe in the same cycle as the bus request. Read data, whether local or from the core, is registered and is presented with a valid pulse one cycle later.

Top module: `usb_bridge_regdec`

## Requirements
- R1: An access of any width at offsets 0x400 to 0x5FF drives core_valid in the same cycle, with core_addr equal to offset bits [8:0], core_we, core_size (0 = byte, 1 = halfword, 2 = word) and core_wdata copied from the bus. A read returns core_rdata on bus_rdata with bus_rvalid high in the next cycle.
- R2: An access at offsets 0x600 to 0x7FF drives core_valid with core_addr = 0x20 + 4 * offset[8:5], so the endpoint FIFO index is offset bits [8:5]. Width and data are passed on unchanged.
- R3: No offset below 0x400 or at 0x800 and above drives core_valid.
- R4: Word writes at 0x800 store the device configuration, and it reads back at 0x800. The host_mode output follows the stored bit 16 from the cycle after the write.
- R5: A word write at 0x800 with bit 15 set stores the value with bit 15 cleared and sets test_mode_err. Only reset clears test_mode_err.
- R6: A word write at 0x908 stores bits [8:0] only, and those bits read back. In the same cycle it pulses epsz_valid with epsz_ep = 0, epsz_size = bits [6:0] and epsz_tx = bit 7.
- R7: Word offsets 0x90C + 4n (transmit) and 0x94C + 4n (receive), for n = 0 to 14, store and read back 32 bits. A write pulses epsz_valid with epsz_ep = n+1, epsz_size = bits [30:0], and epsz_tx = 1 for transmit or 0 for receive.
- R8: Word reads return constants: 0x20 at 0x814 and 0x838, 0x30 at 0x880 and 0x900, 0xA9453C59 at 0x9F8 and 0x54059ADF at 0x9FC.
- R9: The word at 0x9D8 resets to 0xA596, holds 16 bits and is read/write. The scratch word at 0x9C4 resets to 0 and is read/write.
- R10: Byte and halfword accesses outside the two core windows change no register and send no size command. Their reads return 0. Word reads of unmapped local offsets also return 0.
- R11: During and after reset, bus_rdata is 0, bus_rvalid, host_mode and test_mode_err are low, and core_valid is low while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| core_valid | output | 1 | Access strobe toward the USB core |
| core_we | output | 1 | Core write enable |
| core_size | output | 2 | Core access width |
| core_addr | output | 9 | Core register or FIFO address |
| core_wdata | output | 32 | Core write data |
| core_rdata | input | 32 | Core read data, valid in the strobe cycle |
| epsz_valid | output | 1 | Endpoint size command strobe |
| epsz_ep | output | 4 | Endpoint number of the command |
| epsz_size | output | 31 | Transfer size of the command |
| epsz_tx | output | 1 | 1 = transmit direction, 0 = receive |
| host_mode | output | 1 | Host mode select from the device configuration |
| test_mode_err | output | 1 | Sticky flag for a rejected test-mode write |

## Verification
The core strobe, its address and width, and the endpoint size command are combinational on the request, so they are due in the request cycle itself. The bench samples them one time step after driving the inputs at the falling edge, before the next rising edge. Read data, the read valid pulse, host_mode and the error flag each pass through one register, so they are due one cycle after the request. The bench samples them at the following falling edge, after deasserting the request. Checks of ignored accesses read the affected register back in the next access, and they watch the command strobe in the cycle of the ignored access.

// File: rtl/usbrb_pkg.sv
package usbrb_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    WIN_LOCAL = 2'd0,
    WIN_CORE  = 2'd1,
    WIN_FIFO  = 2'd2
  } win_e;

  localparam logic [11:0] OFF_DEVCFG  = 12'h800;
  localparam logic [11:0] OFF_REV_A   = 12'h814;
  localparam logic [11:0] OFF_REV_B   = 12'h838;
  localparam logic [11:0] OFF_REV_C   = 12'h880;
  localparam logic [11:0] OFF_REV_D   = 12'h900;
  localparam logic [11:0] OFF_EP0     = 12'h908;
  localparam logic [11:0] OFF_TXSZ0   = 12'h90C;
  localparam logic [11:0] OFF_RXSZ0   = 12'h94C;
  localparam logic [11:0] OFF_SCRATCH = 12'h9C4;
  localparam logic [11:0] OFF_TRST    = 12'h9D8;
  localparam logic [11:0] OFF_IDW_LO  = 12'h9F8;
  localparam logic [11:0] OFF_IDW_HI  = 12'h9FC;

  localparam logic [31:0] REV_LOW_VAL  = 32'h0000_0020;
  localparam logic [31:0] REV_HIGH_VAL = 32'h0000_0030;
  localparam logic [31:0] IDW_LO_VAL   = 32'hA945_3C59;
  localparam logic [31:0] IDW_HI_VAL   = 32'h5405_9ADF;
  localparam logic [15:0] TRST_INIT    = 16'hA596;

  localparam int DEVCFG_HOST_BIT = 16;
  localparam int DEVCFG_TEST_BIT = 15;

  // FIFO slice index -> core FIFO address: base 0x20, one word per endpoint.
  function automatic logic [8:0] fifo_core_addr(input logic [3:0] slice);
    return 9'h020 + {3'b000, slice, 2'b00};
  endfunction

  // Offset of the n-th register in a word-strided bank.
  function automatic logic [11:0] bank_offset(input logic [11:0] base, input int n);
    return base + 12'(4 * n);
  endfunction

endpackage

// File: rtl/usbrb_window_decode.sv
module usbrb_window_decode
  import usbrb_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CORE_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output win_e              win,
  output logic              core_valid,
  output logic              core_we,
  output logic [1:0]        core_size,
  output logic [CORE_AW-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata
);

  logic [2:0] page;
  assign page = addr[ADDR_W-1 -: 3];

  always_comb begin
    unique case (page)
      3'b010:  win = WIN_CORE;
      3'b011:  win = WIN_FIFO;
      default: win = WIN_LOCAL;
    endcase
  end

  logic fwd;
  assign fwd = req && (win != WIN_LOCAL);

  always_comb begin
    core_addr = '0;
    if (win == WIN_CORE)      core_addr = addr[CORE_AW-1:0];
    else if (win == WIN_FIFO) core_addr = fifo_core_addr(addr[8:5]);
  end

  assign core_valid = fwd;
  assign core_we    = fwd && we;
  assign core_size  = fwd ? size : 2'd0;
  assign core_wdata = fwd ? wdata : '0;

  // R3: the core strobe appears only for offsets 0x400..0x7FF
  p_core_only_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> (req && addr[ADDR_W-1:ADDR_W-2] == 2'b01));

  // R2: FIFO remap lands on a word-aligned address between 0x20 and 0x5C
  p_fifo_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && addr[9]) |-> (core_addr[1:0] == 2'b00 &&
                                 core_addr >= 9'h020 && core_addr <= 9'h05C));

endmodule

// File: rtl/usbrb_sysregs.sv
module usbrb_sysregs
  import usbrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              host_mode,
  output logic              test_err
);

  localparam int TRST_W = 16;

  logic [DATA_W-1:0] devcfg_q;
  logic [DATA_W-1:0] scratch_q;
  logic [TRST_W-1:0] trst_q;
  logic              err_q;

  logic wr_devcfg, wr_scratch, wr_trst, test_req;
  assign wr_devcfg  = wr && (addr == OFF_DEVCFG);
  assign wr_scratch = wr && (addr == OFF_SCRATCH);
  assign wr_trst    = wr && (addr == OFF_TRST);
  assign test_req   = wr_devcfg && wdata[DEVCFG_TEST_BIT];

  logic [DATA_W-1:0] devcfg_keep;
  always_comb begin
    devcfg_keep = wdata;
    devcfg_keep[DEVCFG_TEST_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devcfg_q  <= '0;
      scratch_q <= '0;
      trst_q    <= TRST_INIT;
      err_q     <= 1'b0;
    end else begin
      if (wr_devcfg)  devcfg_q  <= devcfg_keep;
      if (wr_scratch) scratch_q <= wdata;
      if (wr_trst)    trst_q    <= wdata[TRST_W-1:0];
      if (test_req)   err_q     <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      OFF_DEVCFG:             rd_data = devcfg_q;
      OFF_REV_A, OFF_REV_B:   rd_data = REV_LOW_VAL;
      OFF_REV_C, OFF_REV_D:   rd_data = REV_HIGH_VAL;
      OFF_SCRATCH:            rd_data = scratch_q;
      OFF_TRST:               rd_data = {{(DATA_W-TRST_W){1'b0}}, trst_q};
      OFF_IDW_LO:             rd_data = IDW_LO_VAL;
      OFF_IDW_HI:             rd_data = IDW_HI_VAL;
      default:                rd_data = '0;
    endcase
  end

  assign host_mode = devcfg_q[DEVCFG_HOST_BIT];
  assign test_err  = err_q;

  // R5: the error flag never falls once raised
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    test_err |=> test_err);

  // R4: host mode moves only after a configuration write
  p_host_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_devcfg |=> $stable(host_mode));

endmodule

// File: rtl/usbrb_ep_sizes.sv
module usbrb_ep_sizes
  import usbrb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_EP = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic [$clog2(NUM_EP+1)-1:0] cmd_ep,
  output logic [DATA_W-2:0] cmd_size,
  output logic              cmd_tx
);

  localparam int EP_IDX_W = $clog2(NUM_EP + 1);
  localparam int EP0_W    = 9;
  localparam int EP0_SZ_W = 7;

  logic [EP0_W-1:0]  ep0_q;
  logic [DATA_W-1:0] tx_q [NUM_EP];
  logic [DATA_W-1:0] rx_q [NUM_EP];
  logic [NUM_EP-1:0] hit_tx, hit_rx;
  logic              hit_ep0;

  assign hit_ep0 = (addr == OFF_EP0);

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_slot
      localparam logic [11:0] TX_OFF = bank_offset(OFF_TXSZ0, g);
      localparam logic [11:0] RX_OFF = bank_offset(OFF_RXSZ0, g);
      assign hit_tx[g] = (addr == TX_OFF);
      assign hit_rx[g] = (addr == RX_OFF);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep0_q <= '0;
      for (int i = 0; i < NUM_EP; i++) begin
        tx_q[i] <= '0;
        rx_q[i] <= '0;
      end
    end else if (wr) begin
      if (hit_ep0) ep0_q <= wdata[EP0_W-1:0];
      for (int i = 0; i < NUM_EP; i++) begin
        if (hit_tx[i]) tx_q[i] <= wdata;
        if (hit_rx[i]) rx_q[i] <= wdata;
      end
    end
  end

  logic [EP_IDX_W-1:0] tx_ep, rx_ep;
  always_comb begin
    rd_data = '0;
    tx_ep   = '0;
    rx_ep   = '0;
    if (hit_ep0) rd_data = {{(DATA_W-EP0_W){1'b0}}, ep0_q};
    for (int i = 0; i < NUM_EP; i++) begin
      if (hit_tx[i]) begin
        rd_data = tx_q[i];
        tx_ep   = EP_IDX_W'(i + 1);
      end
      if (hit_rx[i]) begin
        rd_data = rx_q[i];
        rx_ep   = EP_IDX_W'(i + 1);
      end
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_ep    = '0;
    cmd_size  = '0;
    cmd_tx    = 1'b0;
    if (wr && hit_ep0) begin
      cmd_valid = 1'b1;
      cmd_size  = {{(DATA_W-1-EP0_SZ_W){1'b0}}, wdata[EP0_SZ_W-1:0]};
      cmd_tx    = wdata[EP0_SZ_W];
    end else if (wr && |hit_tx) begin
      cmd_valid = 1'b1;
      cmd_ep    = tx_ep;
      cmd_size  = wdata[DATA_W-2:0];
      cmd_tx    = 1'b1;
    end else if (wr && |hit_rx) begin
      cmd_valid = 1'b1;
      cmd_ep    = rx_ep;
      cmd_size  = wdata[DATA_W-2:0];
      cmd_tx    = 1'b0;
    end
  end

  // R6: a size command is only ever the result of a local word write
  p_cmd_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> wr);

  // R6: endpoint 0 commands carry a 7-bit size
  p_ep0_size_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ep == '0) |-> (cmd_size[DATA_W-2:EP0_SZ_W] == '0));

  // R7: an offset selects at most one endpoint slot
  p_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_tx, hit_rx, hit_ep0}));

endmodule

// File: rtl/usb_bridge_regdec.sv
module usb_bridge_regdec
  import usbrb_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CORE_AW = 9,
  parameter int NUM_EP  = 15,
  localparam int EP_IDX_W = $clog2(NUM_EP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic                core_valid,
  output logic                core_we,
  output logic [1:0]          core_size,
  output logic [CORE_AW-1:0]  core_addr,
  output logic [DATA_W-1:0]   core_wdata,
  input  logic [DATA_W-1:0]   core_rdata,
  output logic                epsz_valid,
  output logic [EP_IDX_W-1:0] epsz_ep,
  output logic [DATA_W-2:0]   epsz_size,
  output logic                epsz_tx,
  output logic                host_mode,
  output logic                test_mode_err
);

  win_e win;

  usbrb_window_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CORE_AW(CORE_AW)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req),
    .we        (bus_we),
    .size      (bus_size),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .win       (win),
    .core_valid(core_valid),
    .core_we   (core_we),
    .core_size (core_size),
    .core_addr (core_addr),
    .core_wdata(core_wdata)
  );

  // Local registers see only whole-word accesses.
  logic local_word, local_wr, rd_req;
  assign local_word = bus_req && (win == WIN_LOCAL) && (bus_size == ACC_WORD);
  assign local_wr   = local_word && bus_we;
  assign rd_req     = bus_req && !bus_we;

  logic [DATA_W-1:0] sys_rd, ep_rd;

  usbrb_sysregs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_sys (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (local_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rd_data  (sys_rd),
    .host_mode(host_mode),
    .test_err (test_mode_err)
  );

  usbrb_ep_sizes #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_EP(NUM_EP)
  ) u_ep (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (local_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rd_data  (ep_rd),
    .cmd_valid(epsz_valid),
    .cmd_ep   (epsz_ep),
    .cmd_size (epsz_size),
    .cmd_tx   (epsz_tx)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    if (core_valid)      rd_mux = core_rdata;
    else if (local_word) rd_mux = sys_rd | ep_rd;
    else                 rd_mux = '0;
  end

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R1: every read request is answered one cycle later
  p_rvalid_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  // R1: forwarded read data is the core response of the request cycle
  p_core_read_return_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && core_valid) |=> (bus_rdata == $past(core_rdata)));

  // R10: narrow local accesses never emit a size command
  p_narrow_no_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && win == WIN_LOCAL && bus_size != ACC_WORD) |-> !epsz_valid);

  // R10: narrow local reads return zero
  p_narrow_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && win == WIN_LOCAL && bus_size != ACC_WORD) |=> (bus_rdata == '0));

  // R11: no read valid without a preceding read request
  p_no_spurious_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

endmodule

// File: tb/test_usb_bridge_regdec.sv
module test_usb_bridge_regdec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        core_valid, core_we;
  logic [1:0]  core_size;
  logic [8:0]  core_addr;
  logic [31:0] core_wdata, core_rdata;
  logic        epsz_valid, epsz_tx;
  logic [3:0]  epsz_ep;
  logic [30:0] epsz_size;
  logic        host_mode, test_mode_err;

  always #2 clk = ~clk;

  // Core model: echoes the address it was given.
  assign core_rdata = {16'hC0DE, 7'd0, core_addr};

  usb_bridge_regdec i_usb_bridge_regdec (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .core_valid(core_valid), .core_we(core_we), .core_size(core_size),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .epsz_valid(epsz_valid), .epsz_ep(epsz_ep), .epsz_size(epsz_size),
    .epsz_tx(epsz_tx), .host_mode(host_mode), .test_mode_err(test_mode_err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  // Snapshot of the combinational outputs in the request cycle.
  logic        s_cv, s_cwe, s_ev, s_etx;
  logic [1:0]  s_csz;
  logic [8:0]  s_caddr;
  logic [31:0] s_cwd;
  logic [3:0]  s_eep;
  logic [30:0] s_esz;

  task automatic access(input logic we, input logic [1:0] sz,
                        input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
    #1;
    s_cv = core_valid; s_cwe = core_we; s_csz = core_size; s_caddr = core_addr;
    s_cwd = core_wdata; s_ev = epsz_valid; s_eep = epsz_ep; s_esz = epsz_size;
    s_etx = epsz_tx;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [8:0] fifo_exp(input logic [11:0] a);
    logic [11:0] t;
    t = 12'h020 + ((a >> 3) & 12'h03C);
    return t[8:0];
  endfunction

  // {req(4), we(1), size(2), addr(12), wdata(32), expected read(32)}
  localparam int NV = 30;
  localparam logic [82:0] VEC [NV] = '{
    {4'd9,  1'b0, 2'd2, 12'h9C4, 32'h0,        32'h0},         // R9 scratch reset
    {4'd9,  1'b1, 2'd2, 12'h9C4, 32'h12345678, 32'h0},
    {4'd9,  1'b0, 2'd2, 12'h9C4, 32'h0,        32'h12345678},  // R9
    {4'd9,  1'b0, 2'd2, 12'h9D8, 32'h0,        32'h0000A596},  // R9 reset value
    {4'd9,  1'b1, 2'd2, 12'h9D8, 32'hFFFFBEEF, 32'h0},
    {4'd9,  1'b0, 2'd2, 12'h9D8, 32'h0,        32'h0000BEEF},  // R9 16 bits kept
    {4'd8,  1'b0, 2'd2, 12'h814, 32'h0,        32'h00000020},  // R8
    {4'd8,  1'b0, 2'd2, 12'h838, 32'h0,        32'h00000020},  // R8
    {4'd8,  1'b0, 2'd2, 12'h880, 32'h0,        32'h00000030},  // R8
    {4'd8,  1'b0, 2'd2, 12'h900, 32'h0,        32'h00000030},  // R8
    {4'd8,  1'b0, 2'd2, 12'h9F8, 32'h0,        32'hA9453C59},  // R8
    {4'd8,  1'b0, 2'd2, 12'h9FC, 32'h0,        32'h54059ADF},  // R8
    {4'd4,  1'b1, 2'd2, 12'h800, 32'h00010003, 32'h0},
    {4'd4,  1'b0, 2'd2, 12'h800, 32'h0,        32'h00010003},  // R4
    {4'd6,  1'b1, 2'd2, 12'h908, 32'hFFFFFFFF, 32'h0},
    {4'd6,  1'b0, 2'd2, 12'h908, 32'h0,        32'h000001FF},  // R6 nine bits
    {4'd7,  1'b1, 2'd2, 12'h90C, 32'h80000040, 32'h0},
    {4'd7,  1'b0, 2'd2, 12'h90C, 32'h0,        32'h80000040},  // R7
    {4'd7,  1'b1, 2'd2, 12'h984, 32'h00000011, 32'h0},
    {4'd7,  1'b0, 2'd2, 12'h984, 32'h0,        32'h00000011},  // R7 last receive slot
    {4'd7,  1'b0, 2'd2, 12'h94C, 32'h0,        32'h0},         // R7 untouched slot
    {4'd10, 1'b0, 2'd2, 12'h804, 32'h0,        32'h0},         // R10 unmapped word
    {4'd10, 1'b1, 2'd0, 12'h9C4, 32'h000000FF, 32'h0},
    {4'd10, 1'b0, 2'd2, 12'h9C4, 32'h0,        32'h12345678},  // R10 byte write ignored
    {4'd10, 1'b0, 2'd1, 12'h9C4, 32'h0,        32'h0},         // R10 halfword read zero
    {4'd10, 1'b1, 2'd1, 12'h800, 32'h0,        32'h0},
    {4'd10, 1'b0, 2'd2, 12'h800, 32'h0,        32'h00010003},  // R10 halfword write ignored
    {4'd1,  1'b0, 2'd2, 12'h404, 32'h0,        32'hC0DE0004},  // R1 core read
    {4'd2,  1'b0, 2'd2, 12'h6E0, 32'h0,        32'hC0DE003C},  // R2 FIFO read
    {4'd1,  1'b0, 2'd0, 12'h5FF, 32'h0,        32'hC0DE01FF}   // R1 byte core read
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got=%0d exp=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    // R11 during reset
    repeat (3) @(negedge clk);
    chk("R11 rdata in reset", bus_rdata, 32'h0);
    chk("R11 rvalid in reset", {31'd0, bus_rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rdata after reset", bus_rdata, 32'h0);
    chk("R11 host_mode after reset", {31'd0, host_mode}, 32'h0);
    chk("R11 test_mode_err after reset", {31'd0, test_mode_err}, 32'h0);
    chk("R11 core idle", {31'd0, core_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      v = VEC[i];
      access(v[78], v[77:76], v[75:64], v[63:32]);
      if (!v[78]) begin
        chk($sformatf("R%0d table entry %0d rdata", v[82:79], i), bus_rdata, v[31:0]);
        chk($sformatf("R%0d table entry %0d rvalid", v[82:79], i), {31'd0, bus_rvalid}, 32'h1);
      end
    end

    // R4: host mode follows bit 16
    chk("R4 host_mode set", {31'd0, host_mode}, 32'h1);

    // R1: register window pass-through
    access(1'b1, 2'd0, 12'h5FF, 32'h000000A5);
    chk("R1 core_valid", {31'd0, s_cv}, 32'h1);
    chk("R1 core_we", {31'd0, s_cwe}, 32'h1);
    chk("R1 core_size", {30'd0, s_csz}, 32'h0);
    chk("R1 core_addr", {23'd0, s_caddr}, 32'h1FF);
    chk("R1 core_wdata", s_cwd, 32'hA5);
    chk("R1 no size cmd", {31'd0, s_ev}, 32'h0);
    chk("R1 no rvalid after write", {31'd0, bus_rvalid}, 32'h0);

    // R2: FIFO remap
    access(1'b0, 2'd2, 12'h7E0, 32'h0);
    chk("R2 fifo 0x7E0 addr", {23'd0, s_caddr}, {23'd0, fifo_exp(12'h7E0)});
    chk("R2 fifo valid", {31'd0, s_cv}, 32'h1);
    access(1'b1, 2'd1, 12'h61C, 32'h0000BEEF);
    chk("R2 fifo 0x61C addr", {23'd0, s_caddr}, {23'd0, fifo_exp(12'h61C)});
    chk("R2 fifo size", {30'd0, s_csz}, 32'h1);
    chk("R2 fifo wdata", s_cwd, 32'hBEEF);

    // R3: no forwarding outside the windows
    access(1'b0, 2'd2, 12'h3FC, 32'h0);
    chk("R3 below window", {31'd0, s_cv}, 32'h0);
    access(1'b1, 2'd2, 12'h800, 32'h00000000);
    chk("R3 system region", {31'd0, s_cv}, 32'h0);
    chk("R4 host_mode cleared", {31'd0, host_mode}, 32'h0);

    // R6: endpoint 0 command
    access(1'b1, 2'd2, 12'h908, 32'h00000185);
    chk("R6 cmd valid", {31'd0, s_ev}, 32'h1);
    chk("R6 cmd ep", {28'd0, s_eep}, 32'h0);
    chk("R6 cmd size", {1'b0, s_esz}, 32'h5);
    chk("R6 cmd tx", {31'd0, s_etx}, 32'h1);

    // R7: transmit and receive size commands
    access(1'b1, 2'd2, 12'h90C, 32'hFFFFFFFF);
    chk("R7 tx ep", {28'd0, s_eep}, 32'h1);
    chk("R7 tx size", {1'b0, s_esz}, 32'h7FFFFFFF);
    chk("R7 tx dir", {31'd0, s_etx}, 32'h1);
    access(1'b1, 2'd2, 12'h984, 32'h00000033);
    chk("R7 rx ep", {28'd0, s_eep}, 32'hF);
    chk("R7 rx size", {1'b0, s_esz}, 32'h33);
    chk("R7 rx dir", {31'd0, s_etx}, 32'h0);

    // R10: halfword write to endpoint 0 register is ignored
    access(1'b1, 2'd1, 12'h908, 32'h00000003);
    chk("R10 no cmd on narrow write", {31'd0, s_ev}, 32'h0);
    access(1'b0, 2'd2, 12'h908, 32'h0);
    chk("R10 ep0 unchanged", bus_rdata, 32'h00000185);

    // R5: rejected test mode
    access(1'b1, 2'd2, 12'h800, 32'h00018000);
    chk("R5 err raised", {31'd0, test_mode_err}, 32'h1);
    chk("R4 host_mode with test write", {31'd0, host_mode}, 32'h1);
    access(1'b0, 2'd2, 12'h800, 32'h0);
    chk("R5 bit 15 dropped", bus_rdata, 32'h00010000);
    access(1'b1, 2'd2, 12'h800, 32'h00000001);
    chk("R5 err sticky", {31'd0, test_mode_err}, 32'h1);
    access(1'b0, 2'd2, 12'h800, 32'h0);
    chk("R5 clean write stored", bus_rdata, 32'h00000001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule